// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls four 8-bit general-purpose I/O ports through a small synchronous register bus. Each port has a data register, which sets the level the pins drive, and a write-only enable register, which selects the pins that may raise an interrupt. A single shared configuration register gives every port a 2-bit field. That field sets two things at once: the pad drive style (resistive pull-up, push-pull CMOS or open drain) and the pin edge that counts as an interrupt.

In push-pull mode the port cannot raise interrupts. Its enable bits are used as per-pin direction controls instead. Pin inputs pass through a two-flop synchronizer. Qualifying edges on enabled pins are merged into one registered interrupt request, which pulses for one cycle.

Pin n of port p is bit 8p+n of every pin-wide vector.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every data register holds FFh and every enable register holds 00h. The configuration register holds 00h, so all pins are released with the weak pull-up on and no interrupt can fire.
- R2: A write to address p (0 to 3) loads that port's data register, and `pad_out` shows the data registers at all times.
- R3: Addresses 4 to 7 hold the enable registers for ports 0 to 3. They are write-only and read back as 00h. Addresses 9 to 15 also read as 00h.
- R4: Address 8 holds the configuration register, which can be read back. Port p's mode is in bits [2p+1:2p]: 00 is resistive with falling-edge interrupts, 01 is CMOS with no interrupts, 10 is open drain with falling-edge interrupts, and 11 is open drain with rising-edge interrupts.
- R5: In resistive mode, a data bit of 1 gives `pad_oe`=0 and `pad_pu`=1. A data bit of 0 gives `pad_oe`=1 and `pad_pu`=0.
- R6: In CMOS mode, an enable bit of 1 makes the pin an output (`pad_oe`=1), and an enable bit of 0 makes it an input (`pad_oe`=0). `pad_pu` is 0, and edges on the port never raise `irq`.
- R7: In open-drain mode, a data bit of 0 gives `pad_oe`=1, which drives the pin low. A data bit of 1 gives `pad_oe`=0 and `pad_pu`=0.
- R8: A read of address p returns port p's pin levels after the two-flop synchronizer. A level present before clock edge k is read after edge k+1.
- R9: In modes 00 and 10, a falling edge on an enabled pin raises `irq`. In mode 11, a rising edge on an enabled pin raises `irq`. The edge of the opposite direction raises nothing.
- R10: An edge present at the pin before edge k makes `irq` high between edge k+2 and edge k+3, and `irq` then falls again.
- R11: A pin whose enable bit is 0 raises no interrupt. An enable write at edge j applies to edges evaluated at edge j+1 and later, not to the edge evaluated at edge j.
- R12: Qualifying edges on several pins or ports that are evaluated at the same clock edge produce a single one-cycle `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Level driven on each pin when enabled |
| pad_oe | output | 32 | Output enable per pin |
| pad_pu | output | 32 | Weak pull-up enable per pin |
| irq | output | 1 | Combined interrupt request pulse |

## Verification
An enable-register write and the evaluation of a pin edge can land on the same clock edge. The bench provokes this by lowering a pin, waiting two cycles and then writing the enable bit for that pin, so that the write and the evaluation coincide. It then repeats the test with the write one cycle earlier. A reference model of the pipeline timing, updated on every clock, decides whether each case must pulse `irq`. The model also covers mode fields and edges on several ports that are evaluated together.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int NUM_PORTS  = 4;
    localparam int PORT_WIDTH = 8;
    localparam int BUS_AW     = 4;

    typedef enum logic [1:0] {
        MODE_PULLUP   = 2'b00,
        MODE_PUSHPULL = 2'b01,
        MODE_OD_FALL  = 2'b10,
        MODE_OD_RISE  = 2'b11
    } drive_mode_e;

    function automatic drive_mode_e field_mode(input logic [1:0] f);
        return drive_mode_e'(f);
    endfunction
endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs import gpio_pkg::*; #(
    parameter int NP = NUM_PORTS,
    parameter int PW = PORT_WIDTH,
    parameter int AW = BUS_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [PW-1:0]    bus_wdata,
    input  logic [NP*PW-1:0] pins_sync,
    output logic [PW-1:0]    bus_rdata,
    output logic [NP*PW-1:0] data_q,
    output logic [NP*PW-1:0] ie_q,
    output logic [2*NP-1:0]  cfg_q
);
    localparam int CFG_W = 2 * NP;
    localparam logic [AW-1:0] CFG_ADDR = AW'(2 * NP);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '1;
            ie_q   <= '0;
            cfg_q  <= '0;
        end else if (bus_wr) begin
            for (int p = 0; p < NP; p++) begin
                if (bus_addr == AW'(p))      data_q[p*PW +: PW] <= bus_wdata;
                if (bus_addr == AW'(NP + p)) ie_q[p*PW +: PW]   <= bus_wdata;
            end
            if (bus_addr == CFG_ADDR) cfg_q <= bus_wdata[CFG_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NP; p++)
            if (bus_addr == AW'(p)) bus_rdata = pins_sync[p*PW +: PW];
        if (bus_addr == CFG_ADDR) bus_rdata[CFG_W-1:0] = cfg_q;
    end

    assert_cfg_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CFG_ADDR) |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));
endmodule

// File: rtl/gpio_pad_drive.sv
`timescale 1ns/1ps
module gpio_pad_drive import gpio_pkg::*; #(
    parameter int PW = PORT_WIDTH
) (
    input  drive_mode_e   mode,
    input  logic [PW-1:0] data,
    input  logic [PW-1:0] dir,
    output logic [PW-1:0] out,
    output logic [PW-1:0] oe,
    output logic [PW-1:0] pu
);
    always_comb begin
        out = data;
        case (mode)
            MODE_PULLUP: begin
                oe = ~data;
                pu = data;
            end
            MODE_PUSHPULL: begin
                oe = dir;
                pu = '0;
            end
            default: begin
                oe = ~data;
                pu = '0;
            end
        endcase
    end
endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port import gpio_pkg::*; #(
    parameter int PW = PORT_WIDTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pins,
    input  drive_mode_e   mode,
    input  logic [PW-1:0] ie,
    output logic [PW-1:0] level,
    output logic [PW-1:0] hit
);
    logic [PW-1:0] s1_q, s2_q, prev_q;
    logic [PW-1:0] rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '1;
            s2_q   <= '1;
            prev_q <= '1;
        end else begin
            s1_q   <= pins;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_comb begin
        rise = s2_q & ~prev_q;
        fall = ~s2_q & prev_q;
        case (mode)
            MODE_OD_RISE:  hit = rise & ie;
            MODE_PUSHPULL: hit = '0;
            default:       hit = fall & ie;
        endcase
    end

    assign level = s2_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl import gpio_pkg::*; #(
    parameter int N_PORTS = NUM_PORTS,
    parameter int PORT_W  = PORT_WIDTH,
    parameter int ADDR_W  = BUS_AW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [PORT_W-1:0]         bus_wdata,
    output logic [PORT_W-1:0]         bus_rdata,
    input  logic [N_PORTS*PORT_W-1:0] pin_in,
    output logic [N_PORTS*PORT_W-1:0] pad_out,
    output logic [N_PORTS*PORT_W-1:0] pad_oe,
    output logic [N_PORTS*PORT_W-1:0] pad_pu,
    output logic                      irq
);
    localparam int PINS  = N_PORTS * PORT_W;
    localparam int CFG_W = 2 * N_PORTS;

    logic [PINS-1:0]  data_q, ie_q, level, hit;
    logic [CFG_W-1:0] cfg_q;
    logic             irq_q;

    gpio_regs #(.NP(N_PORTS), .PW(PORT_W), .AW(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pins_sync(level), .bus_rdata(bus_rdata),
        .data_q(data_q), .ie_q(ie_q), .cfg_q(cfg_q)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        drive_mode_e mode_p;
        assign mode_p = field_mode(cfg_q[2*p +: 2]);

        gpio_pad_drive #(.PW(PORT_W)) drive_i (
            .mode(mode_p), .data(data_q[p*PORT_W +: PORT_W]),
            .dir(ie_q[p*PORT_W +: PORT_W]), .out(pad_out[p*PORT_W +: PORT_W]),
            .oe(pad_oe[p*PORT_W +: PORT_W]), .pu(pad_pu[p*PORT_W +: PORT_W])
        );

        gpio_edge_port #(.PW(PORT_W)) edge_i (
            .clk(clk), .rst(rst), .pins(pin_in[p*PORT_W +: PORT_W]),
            .mode(mode_p), .ie(ie_q[p*PORT_W +: PORT_W]),
            .level(level[p*PORT_W +: PORT_W]), .hit(hit[p*PORT_W +: PORT_W])
        );

        assert_res_pull_R5: assert property (@(posedge clk) disable iff (rst)
            (mode_p == MODE_PULLUP) |->
            ((pad_pu[p*PORT_W +: PORT_W] ^ pad_oe[p*PORT_W +: PORT_W]) == '1));

        assert_od_low_only_R7: assert property (@(posedge clk) disable iff (rst)
            (mode_p == MODE_OD_FALL || mode_p == MODE_OD_RISE) |->
            ((pad_oe[p*PORT_W +: PORT_W] & pad_out[p*PORT_W +: PORT_W]) == '0
             && pad_pu[p*PORT_W +: PORT_W] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |hit;
    end
    assign irq = irq_q;

    assert_ie_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(N_PORTS) && bus_addr < ADDR_W'(2 * N_PORTS)) |->
        (bus_rdata == '0));

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|ie_q));

    assert_cmos_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == {N_PORTS{2'b01}}) |=> !irq);
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in = '1;
    logic [31:0] pad_out, pad_oe, pad_pu;
    logic        irq;

    always #2.5 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string irq_tag = "R10";

    // reference model state
    bit [7:0]  m_data [4];
    bit [7:0]  m_ie [4];
    bit [7:0]  m_cfg;
    bit [31:0] hist [$];
    bit        m_irq;

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 4; p++) begin m_data[p] = 8'hFF; m_ie[p] = 8'h00; end
            m_cfg = 8'h00;
            m_irq = 1'b0;
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back(32'hFFFF_FFFF);
        end else begin
            bit any;
            any = 1'b0;
            for (int p = 0; p < 4; p++) begin
                bit [7:0] now_l, old_l, edges;
                now_l = hist[1][8*p +: 8];
                old_l = hist[2][8*p +: 8];
                case (m_cfg[2*p +: 2])
                    2'b11:   edges = now_l & ~old_l;
                    2'b01:   edges = 8'h00;
                    default: edges = ~now_l & old_l;
                endcase
                if ((edges & m_ie[p]) != 0) any = 1'b1;
            end
            m_irq = any;
            if (bus_wr) begin
                if (bus_addr < 4)       m_data[bus_addr[1:0]] = bus_wdata;
                else if (bus_addr < 8)  m_ie[bus_addr[1:0]] = bus_wdata;
                else if (bus_addr == 8) m_cfg = bus_wdata;
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit [7:0] er;
        string    rtag;
        for (int p = 0; p < 4; p++) begin
            bit [7:0] eo, ep;
            string    ptag;
            case (m_cfg[2*p +: 2])
                2'b00:   begin eo = ~m_data[p]; ep = m_data[p]; ptag = "R5"; end
                2'b01:   begin eo = m_ie[p];    ep = 8'h00;     ptag = "R6"; end
                default: begin eo = ~m_data[p]; ep = 8'h00;     ptag = "R7"; end
            endcase
            chk(pad_out[8*p +: 8] === m_data[p], "R2", "pad_out", pad_out[8*p +: 8], m_data[p]);
            chk(pad_oe[8*p +: 8] === eo, ptag, "pad_oe", pad_oe[8*p +: 8], eo);
            chk(pad_pu[8*p +: 8] === ep, ptag, "pad_pu", pad_pu[8*p +: 8], ep);
        end
        if (bus_addr < 4)       begin er = hist[1][8*bus_addr[1:0] +: 8]; rtag = "R8"; end
        else if (bus_addr == 8) begin er = m_cfg; rtag = "R4"; end
        else                    begin er = 8'h00; rtag = "R3"; end
        chk(bus_rdata === er, rtag, "bus_rdata", bus_rdata, er);
        chk(irq === m_irq, irq_tag, "irq", irq, m_irq);
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin step(); if (irq === 1'b1) c++; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        step();
        chk(pad_out === 32'hFFFF_FFFF, "R1", "pad_out", pad_out, 32'hFFFF_FFFF);
        chk(pad_oe === 32'h0, "R1", "pad_oe", pad_oe, 32'h0);
        chk(pad_pu === 32'hFFFF_FFFF, "R1", "pad_pu", pad_pu, 32'hFFFF_FFFF);
        bus_addr = 4'd8; step();
        chk(bus_rdata === 8'h00, "R1", "cfg", bus_rdata, 8'h00);

        // R2 data registers
        wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'h0F); wr(4'd3, 8'hF0);
        chk(pad_out === 32'hF00F_3CA5, "R2", "pad_out", pad_out, 32'hF00F_3CA5);

        // R4 one field per port: p0 resistive, p1 CMOS, p2 OD fall, p3 OD rise
        wr(4'd8, 8'hE4);
        bus_addr = 4'd8; step();
        chk(bus_rdata === 8'hE4, "R4", "cfg readback", bus_rdata, 8'hE4);
        chk(pad_oe[7:0] === 8'h5A, "R5", "p0 oe", pad_oe[7:0], 8'h5A);
        chk(pad_oe[15:8] === 8'h00, "R6", "p1 oe", pad_oe[15:8], 8'h00);
        chk(pad_oe[23:16] === 8'hF0, "R7", "p2 oe", pad_oe[23:16], 8'hF0);

        // R3 write-only enables and unused addresses
        wr(4'd5, 8'h0F);
        for (int a = 4; a < 16; a++) begin
            if (a == 8) continue;
            bus_addr = 4'(a); step();
            chk(bus_rdata === 8'h00, "R3", "read", bus_rdata, 8'h00);
        end
        chk(pad_oe[15:8] === 8'h0F, "R6", "p1 direction", pad_oe[15:8], 8'h0F);

        // R8 synchronized readback latency
        bus_addr = 4'd0;
        pin_in = 32'h1234_5678;
        step();
        chk(bus_rdata === 8'hFF, "R8", "one cycle", bus_rdata, 8'hFF);
        step();
        chk(bus_rdata === 8'h78, "R8", "two cycles", bus_rdata, 8'h78);
        bus_addr = 4'd3; step();
        chk(bus_rdata === 8'h12, "R8", "port3", bus_rdata, 8'h12);
        pin_in = '1;
        repeat (4) step();

        // enable interrupts
        irq_tag = "R9";
        wr(4'd4, 8'hFF); wr(4'd6, 8'hFF); wr(4'd7, 8'hFF);

        // R10 timing on a falling edge in resistive mode
        irq_tag = "R10";
        pin_in[0] = 1'b0;
        step(); chk(irq === 1'b0, "R10", "edge k", irq, 1'b0);
        step(); chk(irq === 1'b0, "R10", "edge k+1", irq, 1'b0);
        step(); chk(irq === 1'b1, "R10", "edge k+2", irq, 1'b1);
        step(); chk(irq === 1'b0, "R10", "edge k+3", irq, 1'b0);

        // R9 rise-only on port 3
        irq_tag = "R9";
        pin_in[24] = 1'b0; count_irq(5, c);
        chk(c == 0, "R9", "fall in rise mode", c, 0);
        pin_in[24] = 1'b1; count_irq(5, c);
        chk(c == 1, "R9", "rise in rise mode", c, 1);
        pin_in[20] = 1'b0; count_irq(5, c);
        chk(c == 1, "R9", "fall in OD fall mode", c, 1);

        // R6 CMOS port never interrupts
        irq_tag = "R6";
        pin_in[8] = 1'b0; count_irq(5, c);
        chk(c == 0, "R6", "cmos edge", c, 0);

        // R11 disabled pin and same-cycle enable write
        irq_tag = "R11";
        wr(4'd6, 8'h00);
        pin_in[16] = 1'b0; count_irq(5, c);
        chk(c == 0, "R11", "disabled pin", c, 0);
        pin_in[17] = 1'b0; step(); step();
        wr(4'd6, 8'h02);
        chk(irq === 1'b0, "R11", "enable at evaluation edge", irq, 1'b0);
        count_irq(3, c);
        chk(c == 0, "R11", "late enable", c, 0);
        pin_in[18] = 1'b0; step();
        wr(4'd6, 8'h06);
        step();
        chk(irq === 1'b1, "R11", "enable one cycle early", irq, 1'b1);
        count_irq(3, c);

        // R12 simultaneous edges on two ports
        irq_tag = "R12";
        pin_in[25] = 1'b0; count_irq(5, c);
        pin_in[2] = 1'b0; pin_in[25] = 1'b1;
        count_irq(6, c);
        chk(c == 1, "R12", "merged pulse", c, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule